// File: doc/BRIEF.md
# DDR Framed Word Receiver

This block sits at the far end of a serial link. It receives a data line and the clock forwarded with it, and turns them back into 22-bit parallel words. The forwarded clock is treated as a double-data-rate strobe. Every change of its level carries one bit. A falling level takes an odd-numbered slot and a rising level takes an even-numbered slot. A frame has 26 slots. Slots 1 to 22 carry the word, and slots 23 to 26 carry a fixed boundary pattern that keeps the receiver aligned.

In the model, the block runs on a local clock at least twice the forwarded-clock rate. It finds forwarded-clock edges by comparing two registered samples of the level. The transmitter sends a frame only when it has a word to send. Between frames the forwarded clock stays at one level, and the receiver produces nothing. Edges inside a frame may be spread out by any number of local cycles, so the output rate follows the transmitter's word rate on average.

A two-bit mode input selects either power-down or one of three active settings. All three active settings behave the same. In power-down the parallel outputs are forced to zero, and the output-enable pin is released so that the pads can be put in high impedance.

Top module: `ddr_word_deser`

## Requirements
- R1: A bit is taken from `sdat_i` only on a local cycle where `fclk_i` has a different level from the previous sample. Data on `sdat_i` between edges has no effect, and edges may be any number of local cycles apart.
- R2: A frame is 26 consecutive edges. Slot 1 comes on a falling edge and slot 26 on a rising edge. Slot k (k = 1..22) becomes bit k-1 of `word_o`.
- R3: A word is accepted only when slots 23, 24, 25 and 26 are 1, 1, 0, 0 and slot 26 comes on a rising edge. After reset or power-down, the first frame is accepted once 26 bits have arrived. A marker that ends on a falling edge is not accepted.
- R4: `valid_o` is a single-cycle pulse. It is visible two local cycles after the cycle in which the final edge was applied. `word_o` holds its last value between pulses.
- R5: No edges give no output. Frames sent back to back, or separated by gaps of any length, each give exactly one word.
- R6: While aligned, a frame whose slots 23 to 26 are not 1,1,0,0 is discarded and sets `err_o`. The receiver then realigns on the next correct frame and delivers that frame.
- R7: `err_o` stays set until `rst_n` is low or the mode is power-down. Changing between active modes does not clear it.
- R8: When `mode_i` is 0, `word_o`, `valid_o`, `err_o` and `oe_o` are 0 one cycle later and alignment is lost. Modes 1, 2 and 3 are identical, and `oe_o` is 1 in each of them.
- R9: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, at least twice the forwarded-clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 0 = power-down, 1..3 = active |
| fclk_i | input | 1 | Forwarded link clock level, idles high |
| sdat_i | input | 1 | Serial data line |
| word_o | output | 22 | Last received word |
| valid_o | output | 1 | One-cycle pulse when a new word is on `word_o` |
| err_o | output | 1 | Sticky framing error |
| oe_o | output | 1 | Output-enable for the parallel pads |

## Verification
A word and a framing error both appear two local cycles after the cycle that drives the final edge. One cycle is the capture register and one is the output register. `oe_o` and the power-down clearing follow a mode change by one cycle.

The bench keeps a cycle counter. It stamps the drive cycle of each frame's last edge, and a negative-edge monitor stamps every `valid_o` pulse. Each delivered word is then checked for content and for a latency of exactly two. Checks on levels are made at negative edges, only after enough cycles have passed for both registers.

// File: rtl/ddr_deser_pkg.sv
// Package: shared types for the DDR framed word receiver.
// Assumes: only the alignment state is shared between modules.
package ddr_deser_pkg;

    // Alignment state: searching for a boundary, or counting slots in step.
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } fa_state_e;

endpackage

// File: rtl/ddr_edge_sampler.sv
// Module: ddr_edge_sampler
// Registers the forwarded clock and the data line in the local clock domain.
// Reports one sample per level change of the forwarded clock, together with
// the direction of that change.
// Assumes: the local clock is at least twice the forwarded-clock toggle rate,
// and the forwarded clock idles high.
module ddr_edge_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic fclk_i,
    input  logic sdat_i,
    output logic smp_vld,
    output logic smp_rise,
    output logic smp_bit
);

    logic fclk_r;
    logic fclk_p;
    logic sdat_r;

    // Capture the line pair and keep the previous clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fclk_r <= 1'b1;
            fclk_p <= 1'b1;
            sdat_r <= 1'b0;
        end else begin
            fclk_r <= fclk_i;
            fclk_p <= fclk_r;
            sdat_r <= sdat_i;
        end
    end

    // Any level change is a bit slot; the new level gives the edge direction.
    always_comb begin
        smp_vld  = fclk_r ^ fclk_p;
        smp_rise = fclk_r;
        smp_bit  = sdat_r;
    end

endmodule

// File: rtl/ddr_frame_align.sv
// Module: ddr_frame_align
// Shifts in edge samples, hunts for the boundary marker and then counts
// SLOT_N slots per frame. Flags a complete word or a bad marker for one cycle.
// Assumes: slot 1 of a frame is the oldest bit, and the marker sits in the
// last MARK_W slots. While hunting, a marker is only trusted on a rising edge
// once a full frame of bits has been seen.
module ddr_frame_align
    import ddr_deser_pkg::*;
#(
    parameter int                SLOT_N   = 26,
    parameter int                WORD_W   = 22,
    parameter int                MARK_W   = 4,
    parameter logic [MARK_W-1:0] MARK_PAT = 4'b1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              smp_vld,
    input  logic              smp_rise,
    input  logic              smp_bit,
    output logic [WORD_W-1:0] frm_word,
    output logic              frm_vld,
    output logic              frm_bad
);

    localparam int              CNT_W = $clog2(SLOT_N + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(SLOT_N - 1);

    fa_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic [SLOT_N-2:0] sr_q, sr_d;
    logic [SLOT_N-1:0] win;
    logic             mark_ok;

    // The window as it will be after this sample; bit 0 is the newest slot.
    assign win     = {sr_q, smp_bit};
    assign mark_ok = (win[MARK_W-1:0] == MARK_PAT);
    assign cnt_inc = cnt_q + CNT_W'(1);

    // Slot k of the frame lands on word bit k-1.
    for (genvar i = 0; i < WORD_W; i++) begin : g_word_map
        assign frm_word[i] = win[SLOT_N-1-i];
    end

    // Alignment decisions for the current sample.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sr_d    = sr_q;
        frm_vld = 1'b0;
        frm_bad = 1'b0;
        if (!en) begin
            state_d = ST_HUNT;
            cnt_d   = '0;
            sr_d    = '0;
        end else if (smp_vld) begin
            sr_d = win[SLOT_N-2:0];
            case (state_q)
                ST_HUNT: begin
                    if (smp_rise && cnt_q == LAST && mark_ok) begin
                        frm_vld = 1'b1;
                        state_d = ST_LOCK;
                        cnt_d   = '0;
                    end else if (cnt_q != LAST) begin
                        cnt_d = cnt_inc;
                    end
                end
                ST_LOCK: begin
                    if (cnt_q == LAST) begin
                        cnt_d = '0;
                        if (mark_ok) begin
                            frm_vld = 1'b1;
                        end else begin
                            frm_bad = 1'b1;
                            state_d = ST_HUNT;
                        end
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // Alignment state, slot counter and bit window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            sr_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sr_q    <= sr_d;
        end
    end

    // A word can only complete on an even slot, i.e. a rising edge.
    assert_word_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |-> smp_rise);

    // A rejected frame always drops the receiver back to hunting.
    assert_bad_rehunt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_bad |=> (state_q == ST_HUNT));

endmodule

// File: rtl/ddr_word_reg.sv
// Module: ddr_word_reg
// Output stage: registers the word and its valid pulse, keeps the sticky
// framing error, and drives the pad enable. Power-down zeroes everything.
// Assumes: frm_vld and frm_bad are single-cycle and never high together.
module ddr_word_reg #(
    parameter int WORD_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              frm_vld,
    input  logic              frm_bad,
    input  logic [WORD_W-1:0] frm_word,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              err_o,
    output logic              oe_o
);

    // Register outputs; hold the word between frames and clear on power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            oe_o    <= 1'b0;
        end else if (!en) begin
            word_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            oe_o    <= 1'b0;
        end else begin
            oe_o    <= 1'b1;
            valid_o <= frm_vld;
            err_o   <= err_o | frm_bad;
            if (frm_vld) begin
                word_o <= frm_word;
            end
        end
    end

    // With the pads released, nothing is driven onto the bus.
    assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> (word_o == '0 && !valid_o && !err_o));

    // The error flag survives as long as the receiver stays active.
    assert_sticky_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && en) |=> err_o);

    // Frames are 26 edges long, so valid never lasts two cycles.
    assert_one_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // The word only changes when a new frame completes.
    assert_hold_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && oe_o && !frm_vld) |=> $stable(word_o));

endmodule

// File: rtl/ddr_word_deser.sv
// Module: ddr_word_deser (top)
// DDR framed word receiver. Connects the edge sampler, the frame aligner and
// the output stage. Mode 0 is power-down; every other mode is active.
// Assumes: WORD_W + MARK_W equals SLOT_N.
module ddr_word_deser #(
    parameter int                SLOT_N   = 26,
    parameter int                WORD_W   = 22,
    parameter int                MARK_W   = 4,
    parameter logic [MARK_W-1:0] MARK_PAT = 4'b1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              fclk_i,
    input  logic              sdat_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              err_o,
    output logic              oe_o
);

    logic              en;
    logic              smp_vld, smp_rise, smp_bit;
    logic [WORD_W-1:0] frm_word;
    logic              frm_vld, frm_bad;

    // Any non-zero mode enables the receiver identically.
    assign en = |mode_i;

    ddr_edge_sampler u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .fclk_i   (fclk_i),
        .sdat_i   (sdat_i),
        .smp_vld  (smp_vld),
        .smp_rise (smp_rise),
        .smp_bit  (smp_bit)
    );

    ddr_frame_align #(
        .SLOT_N   (SLOT_N),
        .WORD_W   (WORD_W),
        .MARK_W   (MARK_W),
        .MARK_PAT (MARK_PAT)
    ) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .smp_vld  (smp_vld),
        .smp_rise (smp_rise),
        .smp_bit  (smp_bit),
        .frm_word (frm_word),
        .frm_vld  (frm_vld),
        .frm_bad  (frm_bad)
    );

    ddr_word_reg #(
        .WORD_W (WORD_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .frm_vld  (frm_vld),
        .frm_bad  (frm_bad),
        .frm_word (frm_word),
        .word_o   (word_o),
        .valid_o  (valid_o),
        .err_o    (err_o),
        .oe_o     (oe_o)
    );

endmodule

// File: tb/ddr_word_deser_test.sv
// Bench for ddr_word_deser: a table of frames walked by one loop, then
// directed tests for reset, framing errors, modes and alignment corners.
module ddr_word_deser_test;

    localparam logic [3:0] MARK_OK  = 4'b1100;
    localparam logic [3:0] MARK_BAD = 4'b1000;
    localparam int         NV       = 6;
    localparam logic [21:0] VW [NV] = '{22'h3FFFFF, 22'h000000, 22'h2AAAAA,
                                        22'h155555, 22'h0C3C33, 22'h012345};
    localparam int VS [NV] = '{0, 0, 1, 3, 0, 2};   // extra cycles after each edge
    localparam int VG [NV] = '{4, 0, 0, 7, 1, 20};  // idle cycles after the frame

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'd1;
    logic        fclk_i = 1'b1;
    logic        sdat_i = 1'b0;
    logic [21:0] word_o;
    logic        valid_o, err_o, oe_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_drv = 0;
    int n_cap = 0;
    logic [21:0] cap_w [64];
    int          cap_c [64];
    int          drv_c [NV];

    ddr_word_deser uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .fclk_i  (fclk_i),
        .sdat_i  (sdat_i),
        .word_o  (word_o),
        .valid_o (valid_o),
        .err_o   (err_o),
        .oe_o    (oe_o)
    );

    always #2.5 clk = ~clk;  // 200 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // Log every delivered word with its cycle stamp.
    always @(negedge clk) begin
        if (valid_o) begin
            if (n_cap < 64) begin
                cap_w[n_cap] = word_o;
                cap_c[n_cap] = cyc;
            end
            n_cap = n_cap + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input int stretch);
        @(negedge clk);
        sdat_i   = b;
        fclk_i   = ~fclk_i;
        last_drv = cyc;
        for (int k = 0; k < stretch; k++) begin
            @(negedge clk);
            sdat_i = 1'($urandom);
        end
    endtask

    task automatic send_frame(input logic [21:0] w, input logic [3:0] m, input int stretch);
        for (int k = 0; k < 22; k++) send_bit(w[k], stretch);
        for (int k = 3; k >= 0; k--) send_bit(m[k], stretch);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sdat_i = 1'($urandom);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(word_o == '0, "R9 word", word_o, 0);
        chk(!valid_o && !err_o, "R9 valid/err", {valid_o, err_o}, 0);
        chk(!oe_o, "R9 oe", oe_o, 0);
        rst_n = 1'b1;
        idle(2);
        chk(oe_o, "R8 oe active", oe_o, 1);

        // Table: R1 stretched edges and junk, R2 bit order, R4 latency, R5 gaps
        base = n_cap;
        for (int i = 0; i < NV; i++) begin
            send_frame(VW[i], MARK_OK, VS[i]);
            drv_c[i] = last_drv;
            idle(VG[i]);
        end
        idle(6);
        chk(n_cap == base + NV, "R5 word count", n_cap - base, NV);
        for (int i = 0; i < NV; i++) begin
            chk(cap_w[base+i] == VW[i], "R2 R1 word", cap_w[base+i], VW[i]);
            chk(cap_c[base+i] - drv_c[i] == 2, "R4 latency", cap_c[base+i] - drv_c[i], 2);
        end

        // R4: word holds between pulses
        idle(10);
        chk(word_o == VW[NV-1] && !valid_o, "R4 hold", word_o, VW[NV-1]);

        // R5 R1: no edges give no words whatever the data line does
        base = n_cap;
        idle(50);
        chk(n_cap == base, "R5 idle", n_cap - base, 0);

        // R6: bad marker while aligned, then realignment
        send_frame(22'h0ABCDE, MARK_OK, 0);
        idle(4);
        chk(n_cap == base + 1 && word_o == 22'h0ABCDE, "R6 pre-good", word_o, 22'h0ABCDE);
        send_frame(22'h3FFFFF, MARK_BAD, 0);
        idle(4);
        chk(n_cap == base + 1, "R6 discard", n_cap - base, 1);
        chk(err_o, "R6 err set", err_o, 1);
        send_frame(22'h155AA5, MARK_OK, 1);
        idle(4);
        chk(n_cap == base + 2 && word_o == 22'h155AA5, "R6 realign", word_o, 22'h155AA5);

        // R7: sticky across frames and active-mode changes; R8 mode 3 identical
        mode_i = 2'd3;
        send_frame(22'h2C0FFE, MARK_OK, 0);
        idle(4);
        chk(err_o, "R7 sticky", err_o, 1);
        chk(n_cap == base + 3 && word_o == 22'h2C0FFE, "R8 mode3 word", word_o, 22'h2C0FFE);

        // R8: power-down clears outputs and alignment; R7 error cleared
        mode_i = 2'd0;
        idle(2);
        chk(word_o == '0 && !oe_o, "R8 pd outputs", {oe_o, word_o}, 0);
        chk(!err_o, "R7 pd clears err", err_o, 0);
        base = n_cap;
        send_frame(22'h123456, MARK_OK, 0);
        idle(4);
        chk(n_cap == base && word_o == '0, "R8 pd no word", n_cap - base, 0);

        // R3: marker ending on a falling edge is rejected, rising one accepted
        mode_i = 2'd2;
        idle(2);
        send_bit(1'b0, 0);
        send_frame(22'h000000, MARK_OK, 0);
        send_bit(1'b0, 0);
        idle(4);
        chk(n_cap == base, "R3 falling marker", n_cap - base, 0);
        chk(!err_o, "R3 hunt no err", err_o, 0);
        send_frame(22'h000000, MARK_OK, 0);
        idle(4);
        chk(n_cap == base + 1 && valid_o == 1'b0, "R3 rising marker", n_cap - base, 1);
        send_frame(22'h0F0F0F, MARK_OK, 0);
        idle(4);
        chk(word_o == 22'h0F0F0F, "R3 after lock", word_o, 22'h0F0F0F);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule